// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter. From the oscillator clock it makes a slower count tick and splits every conversion into three phases: zeroing, integration of the input for a fixed time, and integration of the reference until the integrator returns to zero. At any time exactly one of the three phase enables is high. The enables and a reference-polarity select drive the analog switches, which are outside the block. The only analog signal the block reads is the comparator output.

During de-integration a cascade of decimal counters counts ticks. When the comparator reports a zero crossing, the count is the reading: three BCD digits plus a thousands bit. The reading, its sign and an over-range flag are then loaded into an output latch, and a single-clock valid strobe is raised. The conversion length never changes. Time that de-integration does not use goes to the zeroing phase, so readings arrive at a fixed rate.

Top module: `dual_slope_seq`

## Requirements
- R1: Exactly one of `az_o`, `int_o`, `de_o` is high on every clock. While reset is held, `az_o` is high and `digits_o`, `thou_o`, `sign_o`, `over_o`, `valid_o` are all zero.
- R2: The phases always follow the order zeroing (`az_o`), integrate (`int_o`), de-integrate (`de_o`), then zeroing again.
- R3: Integrate lasts exactly INT_COUNTS count ticks. One tick is PRESCALE clocks, so with the defaults it lasts 1000 x 4 = 4000 clocks.
- R4: One conversion, measured from one rise of `int_o` to the next, lasts CYCLE_COUNTS ticks (16000 clocks with the defaults), whatever the reading is.
- R5: The last integrate tick samples the synchronized comparator. A high comparator means a positive input: `ref_neg_o` becomes 1 and the next latched `sign_o` is 0. A low comparator gives `ref_neg_o` 0 and `sign_o` 1. `ref_neg_o` holds its value through de-integrate.
- R6: The comparator passes through a two-flop synchronizer. De-integrate ends on the first tick at which the synchronized comparator differs from the sampled polarity. The reading is the number of de-integrate ticks before that tick, in BCD: `digits_o[3:0]` units, `[7:4]` tens, `[11:8]` hundreds, with `thou_o` for 1000.
- R7: If no crossing occurs within DE_LIMIT ticks (2000), de-integrate ends after exactly DE_LIMIT ticks. The latch then loads `over_o` = 1 with `digits_o` and `thou_o` zero. A conversion that ends on a crossing loads `over_o` = 0.
- R8: `valid_o` is high for exactly one clock: the first clock on which `de_o` is low after de-integrate. The latched outputs change only on that clock.
- R9: After reset is released, the first zeroing phase lasts 1000 ticks. `int_o` first rises on the 4000th clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | oscillator clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cmp_i | input | 1 | comparator, high when the integrator is on the positive side |
| az_o | output | 1 | zeroing phase enable |
| int_o | output | 1 | signal-integrate phase enable |
| de_o | output | 1 | de-integrate phase enable |
| ref_neg_o | output | 1 | reference polarity select for de-integrate |
| digits_o | output | 12 | latched reading, three BCD digits |
| thou_o | output | 1 | latched thousands bit |
| sign_o | output | 1 | latched sign, 1 for a negative input |
| over_o | output | 1 | latched over-range flag |
| valid_o | output | 1 | one-clock strobe when new data is latched |

## Verification
The checker watches the phase enables on every cycle. It checks that exactly one is high, that they follow their order, and that integrate has the right length in clocks. It also checks that the valid strobe is one clock wide and follows de-integrate, that every latched digit is a decimal value, that an over-range result carries a zero reading, and that the reference select holds steady through de-integrate. Only the bench scenarios can show that a reading equals the tick count at which the comparator flipped. The same goes for the sign that comes from each polarity, the 2000-tick limit, the fixed conversion period with short and long readings, and the length of the first zeroing phase after reset.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2
  } phase_e;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/dss_prescale.sv
module dss_prescale #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    cnt_q <= '0;
        else if (cnt_q == W'(DIV - 1)) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == W'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/dss_bcd_counter.sv
module dss_bcd_counter #(
  parameter int DECADES = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   inc_i,
  output logic [4*DECADES-1:0]   digits_o,
  output logic                   thou_o
);
  logic [DECADES:0] carry;
  logic             thou_q;

  assign carry[0] = inc_i;

  for (genvar d = 0; d < DECADES; d++) begin : g_dec
    logic [3:0] dig_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dig_q <= '0;
      else if (clr_i)    dig_q <= '0;
      else if (carry[d]) dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
    end
    assign carry[d+1]        = carry[d] & (dig_q == 4'd9);
    assign digits_o[4*d +: 4] = dig_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            thou_q <= 1'b0;
    else if (clr_i)         thou_q <= 1'b0;
    else if (carry[DECADES]) thou_q <= 1'b1;
  end

  assign thou_o = thou_q;
endmodule

// File: rtl/dss_phase_ctrl.sv
module dss_phase_ctrl
  import dss_pkg::*;
#(
  parameter int INT_COUNTS   = 1000,
  parameter int DE_LIMIT     = 2000,
  parameter int CYCLE_COUNTS = 4000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   cmp_i,
  output phase_e phase_o,
  output logic   pol_o,
  output logic   cnt_clr_o,
  output logic   cnt_inc_o,
  output logic   done_o,
  output logic   over_o
);
  localparam int CYC_W   = $clog2(CYCLE_COUNTS);
  localparam int DE_LAST = INT_COUNTS + DE_LIMIT - 1;
  localparam int AZ_BEG  = INT_COUNTS + DE_LIMIT;

  phase_e           phase_q;
  logic [CYC_W-1:0] cyc_q;
  logic             pol_q;
  logic             int_end, cyc_end, crossed;

  assign int_end = (cyc_q == CYC_W'(INT_COUNTS - 1));
  assign cyc_end = (cyc_q == CYC_W'(CYCLE_COUNTS - 1));
  assign crossed = (cmp_i != pol_q);

  always_comb begin
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    done_o    = 1'b0;
    over_o    = 1'b0;
    if (tick_i) begin
      unique case (phase_q)
        PH_INT: cnt_clr_o = int_end;
        PH_DE: begin
          if (crossed) begin
            done_o = 1'b1;
          end else if (cyc_q == CYC_W'(DE_LAST)) begin
            done_o = 1'b1;
            over_o = 1'b1;
          end else begin
            cnt_inc_o = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AZ;
      cyc_q   <= CYC_W'(AZ_BEG);
      pol_q   <= 1'b0;
    end else if (tick_i) begin
      cyc_q <= cyc_end ? '0 : cyc_q + 1'b1;
      unique case (phase_q)
        PH_AZ:  if (cyc_end) phase_q <= PH_INT;
        PH_INT: if (int_end) begin
                  phase_q <= PH_DE;
                  pol_q   <= cmp_i;
                end
        PH_DE:  if (done_o) phase_q <= PH_AZ;
        default: phase_q <= PH_AZ;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign pol_o   = pol_q;
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int PRESCALE     = 4,
  parameter int INT_COUNTS   = 1000,
  parameter int DE_LIMIT     = 2000,
  parameter int CYCLE_COUNTS = 4000,
  parameter int DECADES      = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmp_i,
  output logic                 az_o,
  output logic                 int_o,
  output logic                 de_o,
  output logic                 ref_neg_o,
  output logic [4*DECADES-1:0] digits_o,
  output logic                 thou_o,
  output logic                 sign_o,
  output logic                 over_o,
  output logic                 valid_o
);
  localparam int DW = 4 * DECADES;

  logic         tick, cmp_s, pol, cnt_clr, cnt_inc, done, over;
  phase_e       phase;
  logic [DW-1:0] cnt_digits;
  logic         cnt_thou;

  dss_prescale #(.DIV(PRESCALE)) i_pre (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick)
  );

  dss_sync #(.STAGES(2)) i_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (cmp_i), .q_o (cmp_s)
  );

  dss_phase_ctrl #(
    .INT_COUNTS  (INT_COUNTS),
    .DE_LIMIT    (DE_LIMIT),
    .CYCLE_COUNTS(CYCLE_COUNTS)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .cmp_i     (cmp_s),
    .phase_o   (phase),
    .pol_o     (pol),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .done_o    (done),
    .over_o    (over)
  );

  dss_bcd_counter #(.DECADES(DECADES)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .inc_i    (cnt_inc),
    .digits_o (cnt_digits),
    .thou_o   (cnt_thou)
  );

  // output latch
  logic [DW-1:0] dig_q;
  logic          thou_q, sign_q, over_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dig_q   <= '0;
      thou_q  <= 1'b0;
      sign_q  <= 1'b0;
      over_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done;
      if (done) begin
        dig_q  <= over ? '0 : cnt_digits;
        thou_q <= over ? 1'b0 : cnt_thou;
        sign_q <= ~pol;
        over_q <= over;
      end
    end
  end

  assign az_o      = (phase == PH_AZ);
  assign int_o     = (phase == PH_INT);
  assign de_o      = (phase == PH_DE);
  assign ref_neg_o = pol;
  assign digits_o  = dig_q;
  assign thou_o    = thou_q;
  assign sign_o    = sign_q;
  assign over_o    = over_q;
  assign valid_o   = valid_q;
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int PRESCALE   = 4,
  parameter int INT_COUNTS = 1000,
  parameter int DECADES    = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 az_o,
  input logic                 int_o,
  input logic                 de_o,
  input logic                 ref_neg_o,
  input logic [4*DECADES-1:0] digits_o,
  input logic                 thou_o,
  input logic                 over_o,
  input logic                 valid_o
);
  logic [31:0] int_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    int_len <= '0;
    else if (int_o) int_len <= int_len + 1;
    else if (az_o)  int_len <= '0;
  end

  assert_one_phase_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({az_o, int_o, de_o}) == 1);

  assert_int_after_az_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_o) |-> $past(az_o));

  assert_de_after_int_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_o) |-> $past(int_o));

  assert_int_length_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_o) |-> int_len == 32'(INT_COUNTS * PRESCALE));

  assert_ref_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && $past(de_o)) |-> $stable(ref_neg_o));

  assert_over_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && over_o) |-> (digits_o == '0 && !thou_o));

  assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_valid_after_de_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (az_o && $past(de_o)));

  assert_latch_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(digits_o));

  for (genvar d = 0; d < DECADES; d++) begin : g_bcd
    assert_bcd_digit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      digits_o[4*d +: 4] <= 4'd9);
  end
endmodule

bind dual_slope_seq dss_checker #(
  .PRESCALE  (PRESCALE),
  .INT_COUNTS(INT_COUNTS),
  .DECADES   (DECADES)
) i_dss_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .az_o      (az_o),
  .int_o     (int_o),
  .de_o      (de_o),
  .ref_neg_o (ref_neg_o),
  .digits_o  (digits_o),
  .thou_o    (thou_o),
  .over_o    (over_o),
  .valid_o   (valid_o)
);

// File: tb/test_dual_slope_seq.sv
module test_dual_slope_seq;
  localparam int P     = 4;
  localparam int CYCLE = 4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmp_i = 1'b1;
  logic        az_o, int_o, de_o, ref_neg_o, thou_o, sign_o, over_o, valid_o;
  logic [11:0] digits_o;

  int checks = 0;
  int failures = 0;
  longint clk_n = 0;
  longint last_int_t = 0;
  bit     have_int_t = 0;
  logic [11:0] prev_digits = '0;
  bit     done = 0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) clk_n++;

  dual_slope_seq i_dual_slope_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp_i),
    .az_o(az_o), .int_o(int_o), .de_o(de_o), .ref_neg_o(ref_neg_o),
    .digits_o(digits_o), .thou_o(thou_o), .sign_o(sign_o),
    .over_o(over_o), .valid_o(valid_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] to_bcd(input int n);
    return {4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // R1 R9: reset state and first zeroing length
  task automatic t_reset();
    int n = 0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 az_o in reset", az_o, 1);
    check("R1 int/de in reset", {int_o, de_o}, 0);
    check("R1 latch in reset", {digits_o, thou_o, sign_o, over_o, valid_o}, 0);
    rst_ni = 1'b1;
    while (!int_o && n < 20000) begin
      @(negedge clk_i);
      n++;
    end
    check("R9 first int rise clock", n, 1000 * P);
  endtask

  // one conversion: reading n (ignored when ovr), polarity pos
  task automatic t_conv(input int n, input bit pos, input bit ovr);
    int     int_n = 0;
    int     de_n = 0;
    int     exp_de;
    longint t0;
    cmp_i = pos;
    while (!int_o) @(negedge clk_i);
    t0 = clk_n;
    if (have_int_t) check("R4 conversion period", t0 - last_int_t, CYCLE * P);
    last_int_t = t0;
    have_int_t = 1;
    check("R8 latch stable before de", digits_o, prev_digits);
    while (int_o) begin
      int_n++;
      @(negedge clk_i);
    end
    check("R3 integrate clocks", int_n, 1000 * P);
    check("R2 de follows int", {az_o, int_o, de_o}, 3'b001);
    check("R5 ref_neg", ref_neg_o, pos);
    if (!ovr) begin
      fork
        begin
          repeat (n * P) @(posedge clk_i);
          @(negedge clk_i);
          cmp_i = ~pos;
        end
      join_none
    end
    while (!valid_o) begin
      if (de_o) de_n++;
      @(negedge clk_i);
    end
    exp_de = ovr ? 2000 * P : (n + 1) * P;
    check(ovr ? "R7 de length at limit" : "R6 de length", de_n, exp_de);
    check("R8 valid with de low", {az_o, de_o}, 2'b10);
    check(ovr ? "R7 digits" : "R6 digits", digits_o, ovr ? 12'd0 : to_bcd(n));
    check(ovr ? "R7 thou" : "R6 thou", thou_o, (!ovr && n >= 1000) ? 1 : 0);
    check("R7 over flag", over_o, ovr);
    check("R5 sign", sign_o, !pos);
    prev_digits = digits_o;
    @(negedge clk_i);
    check("R8 valid one clock", valid_o, 0);
    cmp_i = pos;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_conv(0, 1'b1, 1'b0);
    t_conv(1234, 1'b1, 1'b0);
    t_conv(567, 1'b0, 1'b0);
    t_conv(1999, 1'b0, 1'b0);
    t_conv(0, 1'b1, 1'b1);
    t_conv(9, 1'b0, 1'b0);
    done = 1;
    finish_run();
  end
endmodule